// File: doc/BRIEF.md
# Next Program Counter Unit

This block works out, once per clock, where a 32-bit RISC core fetches next. It takes the current program counter, the raw instruction word and a one-bit result from an equality compare of two register operands. From these it produces the following fetch address. There are five kinds of flow: falling through to the next word, two conditional branches (taken on equal or on not-equal), a plain jump, and a jump that also saves a return address. For the saving jump it also raises a register-write request aimed at register 31 that carries the return address.

Branch displacements are held in the instruction as signed word counts. The block sign-extends them, scales them to bytes and adds them to the address of the following instruction. Jump targets hold 26 bits. These are scaled by four and placed under the top four bits of the following-instruction address, so a jump never leaves its 256 MB aligned region. All outputs are registered. A result therefore appears one cycle after its inputs are sampled. A parameter picks how the branch adder is arranged: either a cascade after the +4 incrementer, or a parallel sum. The two arrangements give the same result.

Top module: `npc_unit`

## Requirements
- R1: While reset is low, `npc_o` is 0x00400000 (the default reset vector), `link_we_o` is 0, `link_addr_o` is 0 and `link_rd_o` is 0. Reset acts at once, without waiting for a clock edge.
- R2: Every output shows the result for the inputs sampled at the previous rising clock edge. A change of inputs between edges leaves the outputs unchanged.
- R3: When the opcode field (instruction bits 31..26) is none of 2, 3, 4 or 5, `npc_o` becomes `pc_i`+4, wrapping modulo 2^32.
- R4: Opcode 4 (branch on equal) with `eq_i`=1 gives `pc_i`+4 plus the sign-extended bits 15..0 multiplied by 4.
- R5: Opcode 5 (branch on not-equal) with `eq_i`=0 gives `pc_i`+4 plus the sign-extended bits 15..0 multiplied by 4.
- R6: A branch whose condition fails (opcode 4 with `eq_i`=0, or opcode 5 with `eq_i`=1) gives `pc_i`+4.
- R7: A branch offset with bit 15 set moves backwards. Offset 0xFFFF lands on `pc_i` itself, and 0x8000 lands 0x20000 bytes below `pc_i`+4.
- R8: Opcode 2 (jump) gives {(`pc_i`+4)[31:28], instruction bits 25..0, 2'b00}.
- R9: The region bits of a jump come from `pc_i`+4 and not from `pc_i`. A jump at 0x0FFFFFFC lands in region 0x1.
- R10: Opcode 3 (jump and save) takes the same target as R8 and sets `link_we_o`=1, `link_addr_o`=`pc_i`+4 and `link_rd_o`=31. Word 0x0C10000C goes to 0x00400030.
- R11: For every opcode other than 3, `link_we_o`, `link_addr_o` and `link_rd_o` are all 0.
- R12: `eq_i` has no effect on the result for jumps and for sequential flow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pc_i | input | 32 | Address of the current instruction |
| instr_i | input | 32 | Current instruction word |
| eq_i | input | 1 | 1 when the two compared register operands are equal |
| npc_o | output | 32 | Next fetch address (registered) |
| link_we_o | output | 1 | Return-address write request |
| link_addr_o | output | 32 | Return address to write |
| link_rd_o | output | 5 | Destination register of the write (31 when requested) |

## Verification
The bench builds two copies of the block with the default 32-bit widths and opcode values. One uses the cascaded branch adder (ADDER_STYLE=0) and the other the parallel adder (ADDER_STYLE=1), and both are held to the same expected values. With 32-bit widths, the cases where the address wraps at the top of the space, jumps that cross a region boundary and the most negative word offset can all be driven directly. Running both adder arrangements shows that each one sign-extends and scales the offset correctly.

// File: rtl/npc_pkg.sv
package npc_pkg;

   typedef enum logic [2:0] {
      FLOW_SEQ = 3'd0,
      FLOW_BEQ = 3'd1,
      FLOW_BNE = 3'd2,
      FLOW_JMP = 3'd3,
      FLOW_JAL = 3'd4
   } flow_e;

   localparam int unsigned BYTE_SHIFT = 2;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
   import npc_pkg::*;
#(
   parameter int unsigned OPC_W   = 6,
   parameter int unsigned OPC_J   = 2,
   parameter int unsigned OPC_JAL = 3,
   parameter int unsigned OPC_BEQ = 4,
   parameter int unsigned OPC_BNE = 5
) (
   input  logic [OPC_W-1:0] opcode_i,
   output flow_e            kind_o
);

   localparam logic [OPC_W-1:0] C_J   = OPC_W'(OPC_J);
   localparam logic [OPC_W-1:0] C_JAL = OPC_W'(OPC_JAL);
   localparam logic [OPC_W-1:0] C_BEQ = OPC_W'(OPC_BEQ);
   localparam logic [OPC_W-1:0] C_BNE = OPC_W'(OPC_BNE);

   always_comb begin
      if (opcode_i == C_BEQ)      kind_o = FLOW_BEQ;
      else if (opcode_i == C_BNE) kind_o = FLOW_BNE;
      else if (opcode_i == C_J)   kind_o = FLOW_JMP;
      else if (opcode_i == C_JAL) kind_o = FLOW_JAL;
      else                        kind_o = FLOW_SEQ;
   end

endmodule

// File: rtl/npc_target.sv
module npc_target
   import npc_pkg::*;
#(
   parameter int unsigned XLEN        = 32,
   parameter int unsigned OFS_W       = 16,
   parameter int unsigned TGT_W       = 26,
   parameter int unsigned ADDER_STYLE = 0
) (
   input  logic [XLEN-1:0]  pc_i,
   input  logic [OFS_W-1:0] offset_i,
   input  logic [TGT_W-1:0] target_i,
   output logic [XLEN-1:0]  pc4_o,
   output logic [XLEN-1:0]  br_tgt_o,
   output logic [XLEN-1:0]  jmp_tgt_o
);

   localparam int unsigned EXT_W    = XLEN - OFS_W;
   localparam int unsigned REGION_W = XLEN - TGT_W - BYTE_SHIFT;
   localparam logic [XLEN-1:0] STEP = XLEN'(1 << BYTE_SHIFT);

   logic [XLEN-1:0] ofs_sx;
   logic [XLEN-1:0] ofs_bytes;

   assign pc4_o     = pc_i + STEP;
   assign ofs_sx    = {{EXT_W{offset_i[OFS_W-1]}}, offset_i};
   assign ofs_bytes = {ofs_sx[XLEN-1-BYTE_SHIFT:0], {BYTE_SHIFT{1'b0}}};

   generate
      if (ADDER_STYLE == 0) begin : g_cascade
         assign br_tgt_o = pc4_o + ofs_bytes;
      end else begin : g_parallel
         logic [XLEN-1:0] ofs_plus_step;
         assign ofs_plus_step = ofs_bytes + STEP;
         assign br_tgt_o      = pc_i + ofs_plus_step;
      end
   endgenerate

   assign jmp_tgt_o = {pc4_o[XLEN-1 -: REGION_W], target_i, {BYTE_SHIFT{1'b0}}};

endmodule

// File: rtl/npc_select.sv
module npc_select
   import npc_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input  flow_e           kind_i,
   input  logic            eq_i,
   input  logic [XLEN-1:0] pc4_i,
   input  logic [XLEN-1:0] br_tgt_i,
   input  logic [XLEN-1:0] jmp_tgt_i,
   output logic [XLEN-1:0] npc_o,
   output logic            link_o
);

   logic br_taken;

   always_comb begin
      br_taken = ((kind_i == FLOW_BEQ) &&  eq_i) ||
                 ((kind_i == FLOW_BNE) && !eq_i);
      link_o   = (kind_i == FLOW_JAL);
      if ((kind_i == FLOW_JMP) || (kind_i == FLOW_JAL)) npc_o = jmp_tgt_i;
      else if (br_taken)                                npc_o = br_tgt_i;
      else                                              npc_o = pc4_i;
   end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
   import npc_pkg::*;
#(
   parameter int unsigned XLEN        = 32,
   parameter int unsigned OPC_W       = 6,
   parameter int unsigned OFS_W       = 16,
   parameter int unsigned TGT_W       = 26,
   parameter int unsigned REG_AW      = 5,
   parameter int unsigned LINK_REG    = 31,
   parameter int unsigned OPC_J       = 2,
   parameter int unsigned OPC_JAL     = 3,
   parameter int unsigned OPC_BEQ     = 4,
   parameter int unsigned OPC_BNE     = 5,
   parameter int unsigned ADDER_STYLE = 0,
   parameter logic [XLEN-1:0] RESET_PC = 32'h0040_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [XLEN-1:0]   pc_i,
   input  logic [XLEN-1:0]   instr_i,
   input  logic              eq_i,
   output logic [XLEN-1:0]   npc_o,
   output logic              link_we_o,
   output logic [XLEN-1:0]   link_addr_o,
   output logic [REG_AW-1:0] link_rd_o
);

   generate
      if (OPC_W + TGT_W != XLEN) begin : g_bad_fields
         $error("opcode and target fields must fill the word");
      end
      if (OFS_W > TGT_W || OFS_W < 2) begin : g_bad_ofs
         $error("offset field width out of range");
      end
      if (XLEN <= TGT_W + BYTE_SHIFT) begin : g_bad_region
         $error("no region bits left above the jump target");
      end
      if (LINK_REG >= (1 << REG_AW)) begin : g_bad_link
         $error("link register index does not fit the register address");
      end
      if (ADDER_STYLE > 1) begin : g_bad_style
         $error("ADDER_STYLE must be 0 or 1");
      end
   endgenerate

   localparam logic [REG_AW-1:0] LINK_IDX = REG_AW'(LINK_REG);

   logic [OPC_W-1:0] opcode;
   logic [OFS_W-1:0] offset;
   logic [TGT_W-1:0] target;
   flow_e            kind;
   logic [XLEN-1:0]  pc4, br_tgt, jmp_tgt, npc_d;
   logic             link_d;

   assign opcode = instr_i[XLEN-1 -: OPC_W];
   assign offset = instr_i[OFS_W-1:0];
   assign target = instr_i[TGT_W-1:0];

   npc_decode #(
      .OPC_W(OPC_W), .OPC_J(OPC_J), .OPC_JAL(OPC_JAL),
      .OPC_BEQ(OPC_BEQ), .OPC_BNE(OPC_BNE)
   ) u_decode (
      .opcode_i (opcode),
      .kind_o   (kind)
   );

   npc_target #(
      .XLEN(XLEN), .OFS_W(OFS_W), .TGT_W(TGT_W), .ADDER_STYLE(ADDER_STYLE)
   ) u_target (
      .pc_i      (pc_i),
      .offset_i  (offset),
      .target_i  (target),
      .pc4_o     (pc4),
      .br_tgt_o  (br_tgt),
      .jmp_tgt_o (jmp_tgt)
   );

   npc_select #(
      .XLEN(XLEN)
   ) u_select (
      .kind_i    (kind),
      .eq_i      (eq_i),
      .pc4_i     (pc4),
      .br_tgt_i  (br_tgt),
      .jmp_tgt_i (jmp_tgt),
      .npc_o     (npc_d),
      .link_o    (link_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         npc_o       <= RESET_PC;
         link_we_o   <= 1'b0;
         link_addr_o <= '0;
         link_rd_o   <= '0;
      end else begin
         npc_o       <= npc_d;
         link_we_o   <= link_d;
         link_addr_o <= link_d ? pc4 : '0;
         link_rd_o   <= link_d ? LINK_IDX : '0;
      end
   end

endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
   parameter int unsigned XLEN     = 32,
   parameter int unsigned OPC_W    = 6,
   parameter int unsigned REG_AW   = 5,
   parameter int unsigned LINK_REG = 31,
   parameter int unsigned OPC_J    = 2,
   parameter int unsigned OPC_JAL  = 3,
   parameter int unsigned OPC_BEQ  = 4,
   parameter int unsigned OPC_BNE  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic [XLEN-1:0]   pc_i,
   input logic [OPC_W-1:0]  opc_i,
   input logic              eq_i,
   input logic [XLEN-1:0]   npc_o,
   input logic              link_we_o,
   input logic [XLEN-1:0]   link_addr_o,
   input logic [REG_AW-1:0] link_rd_o
);

   logic            seen;
   logic [XLEN-1:0] pc4_w;
   logic            is_jump, is_branch;

   assign pc4_w     = pc_i + XLEN'(4);
   assign is_jump   = (opc_i == OPC_W'(OPC_J)) || (opc_i == OPC_W'(OPC_JAL));
   assign is_branch = (opc_i == OPC_W'(OPC_BEQ)) || (opc_i == OPC_W'(OPC_BNE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen <= 1'b0;
      else        seen <= 1'b1;
   end

   assert_seq_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && !$past(is_jump) && !$past(is_branch)) |-> (npc_o == $past(pc4_w)));

   assert_branch_fail_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && (($past(opc_i) == OPC_W'(OPC_BEQ) && !$past(eq_i)) ||
                ($past(opc_i) == OPC_W'(OPC_BNE) &&  $past(eq_i))))
      |-> (npc_o == $past(pc4_w)));

   assert_jump_region_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && $past(is_jump)) |->
      ((npc_o[1:0] == 2'b00) && (npc_o[XLEN-1:XLEN-4] == $past(pc4_w[XLEN-1:XLEN-4]))));

   assert_link_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && ($past(opc_i) == OPC_W'(OPC_JAL))) |->
      (link_we_o && (link_rd_o == REG_AW'(LINK_REG)) && (link_addr_o == $past(pc4_w))));

   assert_no_link_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && ($past(opc_i) != OPC_W'(OPC_JAL))) |->
      (!link_we_o && (link_rd_o == '0) && (link_addr_o == '0)));

endmodule

bind npc_unit npc_unit_chk #(
   .XLEN(XLEN), .OPC_W(OPC_W), .REG_AW(REG_AW), .LINK_REG(LINK_REG),
   .OPC_J(OPC_J), .OPC_JAL(OPC_JAL), .OPC_BEQ(OPC_BEQ), .OPC_BNE(OPC_BNE)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pc_i        (pc_i),
   .opc_i       (instr_i[XLEN-1 -: OPC_W]),
   .eq_i        (eq_i),
   .npc_o       (npc_o),
   .link_we_o   (link_we_o),
   .link_addr_o (link_addr_o),
   .link_rd_o   (link_rd_o)
);

// File: tb/npc_unit_bench.sv
module npc_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pc_i = '0;
   logic [31:0] instr_i = '0;
   logic        eq_i = 1'b0;

   logic [31:0] npc_a, laddr_a, npc_b, laddr_b;
   logic        lwe_a, lwe_b;
   logic [4:0]  lrd_a, lrd_b;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   npc_unit #(.ADDER_STYLE(0)) u_npc_unit (
      .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .instr_i(instr_i), .eq_i(eq_i),
      .npc_o(npc_a), .link_we_o(lwe_a), .link_addr_o(laddr_a), .link_rd_o(lrd_a));

   npc_unit #(.ADDER_STYLE(1)) u_npc_unit_alt (
      .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .instr_i(instr_i), .eq_i(eq_i),
      .npc_o(npc_b), .link_we_o(lwe_b), .link_addr_o(laddr_b), .link_rd_o(lrd_b));

   // {tag, pc, instr, eq, expected next pc, expected link write}
   localparam int NV = 15;
   localparam logic [101:0] VEC [NV] = '{
      {4'd3,  32'h0040_0000, 32'h0062_2020, 1'b0, 32'h0040_0004, 1'b0}, // R3 opcode 0
      {4'd12, 32'h0040_0010, 32'h8C45_0BB8, 1'b1, 32'h0040_0014, 1'b0}, // R12 R3 opcode 0x23, eq ignored
      {4'd4,  32'h0040_0100, 32'h1009_000A, 1'b1, 32'h0040_012C, 1'b0}, // R4 +10 words
      {4'd6,  32'h0040_0100, 32'h1009_000A, 1'b0, 32'h0040_0104, 1'b0}, // R6 equal-branch falls through
      {4'd5,  32'h0040_0200, 32'h1400_0003, 1'b0, 32'h0040_0210, 1'b0}, // R5 +3 words
      {4'd6,  32'h0040_0200, 32'h1400_0003, 1'b1, 32'h0040_0204, 1'b0}, // R6 not-equal-branch falls through
      {4'd7,  32'h0040_0300, 32'h1000_FFFF, 1'b1, 32'h0040_0300, 1'b0}, // R7 offset -1 word
      {4'd7,  32'h0044_0000, 32'h1400_8000, 1'b0, 32'h0042_0004, 1'b0}, // R7 most negative offset
      {4'd8,  32'h0040_0000, 32'h0812_3456, 1'b0, 32'h0048_D158, 1'b0}, // R8 jump
      {4'd9,  32'h0FFF_FFFC, 32'h0800_0010, 1'b0, 32'h1000_0040, 1'b0}, // R9 region from pc+4
      {4'd8,  32'hA000_1000, 32'h0BFF_FFFF, 1'b0, 32'hAFFF_FFFC, 1'b0}, // R8 all-ones target
      {4'd10, 32'h0040_0020, 32'h0C10_000C, 1'b0, 32'h0040_0030, 1'b1}, // R10 jump and save
      {4'd12, 32'h3000_0000, 32'h0C00_0001, 1'b1, 32'h3000_0004, 1'b1}, // R12 R10 eq ignored
      {4'd3,  32'hFFFF_FFFC, 32'h0000_0000, 1'b0, 32'h0000_0000, 1'b0}, // R3 wrap
      {4'd12, 32'h0040_0000, 32'h0800_0004, 1'b1, 32'h0000_0010, 1'b0}  // R12 jump, eq ignored
   };

   task automatic check32(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic check_both(input string req, input logic [31:0] enpc,
                             input logic ewe, input logic [31:0] eaddr);
      check32(req, "npc style0", npc_a, enpc);
      check32(req, "npc style1", npc_b, enpc);
      check32(req, "link_we style0", {31'd0, lwe_a}, {31'd0, ewe});
      check32(req, "link_we style1", {31'd0, lwe_b}, {31'd0, ewe});
      check32(req, "link_addr", laddr_a, eaddr);
      check32(req, "link_addr alt", laddr_b, eaddr);
      check32(req, "link_rd", {27'd0, lrd_a}, ewe ? 32'd31 : 32'd0);
      check32(req, "link_rd alt", {27'd0, lrd_b}, ewe ? 32'd31 : 32'd0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R1: state held in reset, even with a jump-and-save word applied
      instr_i = 32'h0C10_000C;
      pc_i    = 32'h1234_5670;
      repeat (3) @(negedge clk);
      check_both("R1", 32'h0040_0000, 1'b0, 32'h0);
      rst_n = 1'b1;

      // table walk
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         pc_i    = VEC[i][97:66];
         instr_i = VEC[i][65:34];
         eq_i    = VEC[i][33];
         @(negedge clk);
         check_both($sformatf("R%0d", VEC[i][101:98]), VEC[i][32:1], VEC[i][0],
                    VEC[i][0] ? (VEC[i][97:66] + 32'd4) : 32'h0);
      end

      // R11: a branch following a jump-and-save clears the write request
      @(negedge clk);
      pc_i = 32'h0040_0020; instr_i = 32'h0C10_000C; eq_i = 1'b0;
      @(negedge clk);
      pc_i = 32'h0040_0030; instr_i = 32'h1009_0001; eq_i = 1'b1;
      @(negedge clk);
      check_both("R11", 32'h0040_0038, 1'b0, 32'h0);

      // R2: input change between edges does not reach the outputs
      pc_i = 32'h0050_0000; instr_i = 32'h0000_0000; eq_i = 1'b0;
      #2;
      check_both("R2", 32'h0040_0038, 1'b0, 32'h0);
      @(negedge clk);
      check_both("R2", 32'h0050_0004, 1'b0, 32'h0);

      // R1: reset asserted mid-run acts without a clock edge
      pc_i = 32'h0040_0020; instr_i = 32'h0C10_000C;
      @(negedge clk);
      check_both("R10", 32'h0040_0030, 1'b1, 32'h0040_0024);
      #1 rst_n = 1'b0;
      #1;
      check_both("R1", 32'h0040_0000, 1'b0, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_both("R10", 32'h0040_0030, 1'b1, 32'h0040_0024);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule